// File: doc/BRIEF.md
# Sigma-Delta Converter Feedback Loop

This block is the digital side of a first-order sigma-delta converter. A single threshold-sensing input pin watches the node of an external RC integrator, and a single drive pin feeds that node back through a resistor. On every strobe of a fixed-rate tick enable, the block takes one registered sample of the synchronized input. It drives the feedback pin to the opposite level. It counts the ticks on which the drive was set low, which are the ticks on which the input was sensed high.

The count is gathered over a window of 256 ticks in base mode. In extended mode the window is sixteen times longer, and the low four bits of the total are dropped. At the end of each window the block publishes the result with a one-cycle valid strobe. It also raises a saturation flag when every tick of the window saw the same level. The integrator, comparator threshold and any scaling for display live outside the block.

Top module: `sd_loop_core`

## Requirements
- R1: `sense_in` is asynchronous and passes through two synchronizing flops. A tick samples the value `sense_in` held at least two clocks before the tick edge.
- R2: On a clock edge where `tick` is high, `drive_out` takes the inverse of the sampled input: 0 when the input was 1, and 1 when it was 0. Between ticks `drive_out` holds its value.
- R3: During and after reset, `drive_out`, `result`, `result_valid` and `saturated` are 0, and the window and count state start from zero.
- R4: The count grows by one for each tick whose drive was written low (input sensed 1), and only for such ticks.
- R5: In base mode a window spans 256 ticks, and `result` equals the count. A full count of 256 is clipped to 255.
- R6: In extended mode (`ext_mode`=1) a window spans 4096 ticks. `result` is the total shifted right by 4, and a value of 256 is clipped to 255.
- R7: `result_valid` is high for exactly one clock, one clock after the edge that registered the window's last tick. The count restarts from zero for the next window.
- R8: `saturated` is set with each published result when the window's count was zero or equal to the window length. It holds, together with `result`, until the next publish.
- R9: `ext_mode` is read only when a result is published, and it selects the next window. The first window after reset is a base window.
- R10: While `tick` is low, `sense_in` activity changes neither `drive_out`, the count, nor the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe pacing the loop |
| ext_mode | input | 1 | 1 selects the extended window for the next window |
| sense_in | input | 1 | Asynchronous threshold input from the integrator node |
| drive_out | output | 1 | Registered feedback drive, the inverse of the last sample |
| result | output | 8 | Last published conversion value |
| result_valid | output | 1 | One-cycle strobe marking a new `result` |
| saturated | output | 1 | Last window was all ones or all zeros |

## Verification
`drive_out` is due on the first clock after the tick edge. The bench holds `sense_in` steady for three clocks before each tick and reads the drive at the falling edge that follows the tick. `result`, `result_valid` and `saturated` are due one clock later than the drive of the last tick of the window. The bench therefore waits two falling edges after that tick, plus a small delay, before comparing. A falling-edge monitor logs every valid strobe and checks that it never lasts two samples. Window totals are predicted from the bench's own count of high inputs, with the shift and clip applied by a bench function.

// File: rtl/sd_loop_pkg.sv
package sd_loop_pkg;
  typedef enum logic {MODE_BASE = 1'b0, MODE_EXT = 1'b1} sd_mode_e;
endpackage

// File: rtl/sd_sync2.sv
module sd_sync2 #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sd_bit_slice.sv
module sd_bit_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sync_bit,
  output logic drive_out,
  output logic smp_valid
);
  logic drive_q;
  logic valid_q;

  // one sample per tick: drive and count both follow drive_q
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= tick;
      if (tick) drive_q <= ~sync_bit;
    end
  end

  assign drive_out = drive_q;
  assign smp_valid = valid_q;

  // R2: drive is the inverse of the value seen at the tick edge
  assert_drive_inverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (drive_out == !$past(sync_bit)));

  // R10: no tick, no drive change
  assert_drive_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(drive_out));
endmodule

// File: rtl/sd_window_acc.sv
module sd_window_acc #(
  parameter int WIN_BITS = 8,
  parameter int EXT_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic                drive_low,
  input  logic                ext_mode,
  output logic                win_last,
  output logic [WIN_BITS-1:0] result,
  output logic                result_valid,
  output logic                saturated
);
  import sd_loop_pkg::*;

  localparam int CNT_W = WIN_BITS + EXT_BITS;
  localparam int TOT_W = CNT_W + 1;
  localparam logic [TOT_W-1:0] SPAN_BASE = TOT_W'(1) << WIN_BITS;
  localparam logic [TOT_W-1:0] SPAN_EXT  = TOT_W'(1) << CNT_W;
  localparam logic [CNT_W-1:0] LAST_BASE = CNT_W'(SPAN_BASE - 1'b1);
  localparam logic [CNT_W-1:0] LAST_EXT  = CNT_W'(SPAN_EXT - 1'b1);
  localparam logic [TOT_W-1:0] OUT_MAX   = (TOT_W'(1) << WIN_BITS) - 1'b1;

  function automatic logic [WIN_BITS-1:0] fold_total(input logic [TOT_W-1:0] tot,
                                                     input sd_mode_e m);
    logic [TOT_W-1:0] sh;
    sh = (m == MODE_EXT) ? (tot >> EXT_BITS) : tot;
    if (sh > OUT_MAX) sh = OUT_MAX;
    return sh[WIN_BITS-1:0];
  endfunction

  function automatic logic is_extreme(input logic [TOT_W-1:0] tot,
                                      input sd_mode_e m);
    return (tot == '0) || (tot == ((m == MODE_EXT) ? SPAN_EXT : SPAN_BASE));
  endfunction

  sd_mode_e            mode_q;
  logic [CNT_W-1:0]    tcnt_q;
  logic [TOT_W-1:0]    total_q;
  logic [TOT_W-1:0]    total_nx;
  logic                inc;
  logic [WIN_BITS-1:0] res_q;
  logic                vld_q;
  logic                sat_q;

  assign inc      = smp_valid & drive_low;
  assign total_nx = total_q + TOT_W'(inc);
  assign win_last = smp_valid &&
                    (tcnt_q == ((mode_q == MODE_EXT) ? LAST_EXT : LAST_BASE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_BASE;
      tcnt_q  <= '0;
      total_q <= '0;
      res_q   <= '0;
      vld_q   <= 1'b0;
      sat_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (win_last) begin
        res_q   <= fold_total(total_nx, mode_q);
        sat_q   <= is_extreme(total_nx, mode_q);
        vld_q   <= 1'b1;
        tcnt_q  <= '0;
        total_q <= '0;
        mode_q  <= ext_mode ? MODE_EXT : MODE_BASE;
      end else if (smp_valid) begin
        tcnt_q  <= tcnt_q + 1'b1;
        total_q <= total_nx;
      end
    end
  end

  assign result       = res_q;
  assign result_valid = vld_q;
  assign saturated    = sat_q;

  // R7: strobe lasts one cycle and the count restarts
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  assert_count_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (total_q == '0 && tcnt_q == '0));
  // R4: count never exceeds the ticks seen so far in the window
  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    total_q <= TOT_W'(tcnt_q));
  // R10: no sample, no count change
  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(total_q));
  // R8: saturation only with an end-of-scale value
  assert_sat_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && saturated) |-> (result == '0 || result == OUT_MAX[WIN_BITS-1:0]));
endmodule

// File: rtl/sd_loop_core.sv
module sd_loop_core #(
  parameter int WIN_BITS    = 8,
  parameter int EXT_BITS    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                ext_mode,
  input  logic                sense_in,
  output logic                drive_out,
  output logic [WIN_BITS-1:0] result,
  output logic                result_valid,
  output logic                saturated
);
  logic sense_sync;
  logic smp_valid;
  logic win_last;

  sd_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sense_in), .q(sense_sync)
  );

  sd_bit_slice u_slice (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sync_bit(sense_sync),
    .drive_out(drive_out), .smp_valid(smp_valid)
  );

  sd_window_acc #(.WIN_BITS(WIN_BITS), .EXT_BITS(EXT_BITS)) u_acc (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .drive_low(~drive_out),
    .ext_mode(ext_mode), .win_last(win_last), .result(result),
    .result_valid(result_valid), .saturated(saturated)
  );

  // R7: a publish follows the last sample of a window by one cycle
  assert_publish_timing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |=> result_valid);
endmodule

// File: tb/sd_loop_core_test.sv
`timescale 1ns/1ps
module sd_loop_core_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic ext_mode = 1'b0;
  logic sense_in = 1'b0;
  logic drive_out;
  logic [7:0] result;
  logic result_valid;
  logic saturated;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  logic [7:0] got_res;
  logic got_sat;
  logic prev_vld = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sd_loop_core uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ext_mode(ext_mode),
    .sense_in(sense_in), .drive_out(drive_out), .result(result),
    .result_valid(result_valid), .saturated(saturated)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_value(input int highs, input bit ext);
    int v;
    v = ext ? (highs >> 4) : highs;
    return (v > 255) ? 255 : v;
  endfunction

  function automatic bit expect_sat(input int highs, input bit ext);
    return (highs == 0) || (highs == (ext ? 4096 : 256));
  endfunction

  // monitor for R7 strobe width
  always @(negedge clk) begin
    if (rst_n && result_valid) begin
      pulses++;
      got_res = result;
      got_sat = saturated;
      check(!prev_vld, "R7 valid width", 2, 1);
    end
    prev_vld = result_valid;
  end

  task automatic do_tick(input logic b);
    @(negedge clk) sense_in = b;
    repeat (2) @(negedge clk);
    tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    check(drive_out == ~b, "R2 drive inverse", drive_out, ~b);
  endtask

  task automatic idle_gap(input int n);
    logic d0;
    int p0;
    d0 = drive_out;
    p0 = pulses;
    for (int k = 0; k < n; k++) @(negedge clk) sense_in = ~sense_in;
    check(drive_out == d0, "R10 drive held", drive_out, d0);
    check(pulses == p0, "R10 no publish", pulses, p0);
  endtask

  // density: percent chance of a high sample; <0 all low, >100 all high
  task automatic run_window(input bit ext, input int density, input int gap_at,
                            input bit flip_mode_at_mid, input string tag);
    int n, highs, p0;
    logic b;
    n = ext ? 4096 : 256;
    highs = 0;
    p0 = pulses;
    for (int i = 0; i < n; i++) begin
      if (density < 0) b = 1'b0;
      else if (density > 100) b = 1'b1;
      else b = (($urandom % 100) < density);
      if (b) highs++;
      if (i == gap_at) idle_gap(40);
      if (flip_mode_at_mid && i == n / 2) ext_mode = ~ext_mode;
      do_tick(b);
    end
    repeat (2) @(negedge clk);
    #1;
    check(pulses == p0 + 1, {tag, " one publish"}, pulses - p0, 1);
    check(got_res == expect_value(highs, ext), {tag, " value"}, got_res,
          expect_value(highs, ext));
    check(got_sat == expect_sat(highs, ext), {tag, " R8 saturation"}, got_sat,
          expect_sat(highs, ext));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R3: reset state
    check(drive_out == 1'b0, "R3 drive", drive_out, 0);
    check(result == 8'd0, "R3 result", result, 0);
    check(result_valid == 1'b0, "R3 valid", result_valid, 0);
    check(saturated == 1'b0, "R3 sat", saturated, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(drive_out == 1'b0, "R3 drive after release", drive_out, 0);

    // R1/R4/R5 random base windows at several densities
    run_window(1'b0, 50, -1, 1'b0, "R5 R4 half");
    run_window(1'b0, 20, 100, 1'b0, "R5 R10 sparse with gap");
    run_window(1'b0, 85, -1, 1'b0, "R5 R1 dense");
    // R5/R8 extremes
    run_window(1'b0, 101, -1, 1'b0, "R5 all high clip");
    run_window(1'b0, -1, -1, 1'b0, "R5 all low");
    // R9: mode flips mid-window, this window stays base
    run_window(1'b0, 60, -1, 1'b1, "R9 base kept");
    // R6: extended windows
    run_window(1'b1, 40, -1, 1'b0, "R6 ext random");
    run_window(1'b1, 101, -1, 1'b0, "R6 ext all high clip");
    ext_mode = 1'b0;
    run_window(1'b1, 73, 2000, 1'b0, "R6 R9 ext then base");
    // R9: back to base
    run_window(1'b0, 30, -1, 1'b0, "R9 base again");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule